// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds the 64-bit control register that places the memory-mapped PCIe configuration window in the physical address space. It turns the register into a decoded window: an enable, a base aligned to the chosen window size, the window length in bytes, and a combinational hit flag for an address presented on `addr_i`. It also reports the bounds of the 32-bit PCI memory hole that sits above the window. That lets the address map around it follow any move of the window.

Software writes the register through a byte-lane write port, so any mix of the eight bytes can change in one access. The register also reads back on a read port. Every decode output is derived combinationally from the stored register value, so each write takes effect on the edge that stores it. A reserved size code raises an error flag, disables the window and never yields a hit.

Top module: `cfgwin_decoder`

## Requirements
- R1: After the active-low asynchronous reset the register reads 0x0000_0000_4000_0000: enable clear, size code 00 and base 1 GB. The outputs then show win_en_o=0, hit_o=0, len_err_o=0 and hole_start_o=0x4000_0000.
- R2: While wr_en_i is high, each set bit j of wr_be_i loads byte j (bits 8j+7..8j) of wr_data_i on the rising clock edge. Bytes whose enable is clear keep their value, and nothing changes while wr_en_i is low.
- R3: Only bit 0 (enable), bits 2..1 (size code) and bits PA_W-1..26 (base) are storable. All other register bits read back as zero.
- R4: Size code 00 gives a 256 MB window (win_len_o=0x1000_0000), 01 gives 128 MB and 10 gives 64 MB. Code 11 is reserved: it sets len_err_o and drives win_len_o to zero.
- R5: win_base_o is the register ANDed with a size-dependent mask. For code 00 and code 11 the mask is bits PA_W-1..28. Code 01 also keeps bits 27 and 26. Code 10 also keeps bit 26 only.
- R6: win_en_o is high exactly when bit 0 is set and the size code is not reserved.
- R7: hit_o is high, in the same cycle as addr_i, exactly when win_en_o is high and win_base_o <= addr_i < win_base_o + win_len_o. The sum is taken without wrap-around.
- R8: With the reserved size code, hit_o stays low for every address, whatever the enable bit holds.
- R9: hole_start_o equals the low 32 bits of win_base_o + win_len_o while win_en_o is high. Otherwise it equals the low 32 bits of the reset-default base (0x4000_0000).
- R10: hole_end_o is always one byte below the I/O interrupt controller default address, that is 0xFEBF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 8 | Byte-lane enables for the write |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Current register value |
| addr_i | input | PA_W (40) | Address to decode |
| win_en_o | output | 1 | Window enabled and size valid |
| win_base_o | output | PA_W (40) | Size-aligned window base |
| win_len_o | output | 29 | Window length in bytes, zero if reserved |
| hit_o | output | 1 | addr_i falls inside the window |
| len_err_o | output | 1 | Reserved size code programmed |
| hole_start_o | output | 32 | First byte of the 32-bit PCI hole |
| hole_end_o | output | 32 | Last byte of the 32-bit PCI hole |

## Verification
The bench probes both edges of each window size: the first byte hits, and the byte at base plus length misses. A comparator off by one at either end would show up there. The 64 MB case is written with bit 27 set, so a design that kept bit 27 would move its base and miss the expected hit. The bench also programs a base at the top of the address space, where a narrow sum would wrap and drop the hit. It then checks the reserved code with the enable set, where a design treating it as a valid size would hit or move the hole. Partial byte writes and writes with the strobe low expose lanes that leak into their neighbours.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_128M = 2'b01,
    SZ_64M  = 2'b10,
    SZ_RSVD = 2'b11
  } win_size_e;

  localparam int unsigned EN_BIT      = 0;
  localparam int unsigned SZ_LSB      = 1;
  localparam int unsigned BASE_LSB    = 26;
  localparam int unsigned COARSE_LSB  = 28;
  localparam int unsigned LEN_W       = 29;

endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg #(
  parameter int unsigned      REG_W   = 64,
  parameter logic [REG_W-1:0] RST_VAL = '0,
  parameter logic [REG_W-1:0] WMASK   = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_W/8-1:0]   be_i,
  input  logic [REG_W-1:0]     d_i,
  output logic [REG_W-1:0]     q_o
);
  localparam int unsigned NBYTES = REG_W / 8;

  logic [7:0] byte_q [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    localparam logic [7:0] LANE_MASK = WMASK[b*8 +: 8];
    localparam logic [7:0] LANE_RST  = RST_VAL[b*8 +: 8] & LANE_MASK;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q[b] <= LANE_RST;
      end else if (wr_en_i && be_i[b]) begin
        byte_q[b] <= d_i[b*8 +: 8] & LANE_MASK;
      end
    end

    assign q_o[b*8 +: 8] = byte_q[b];
  end
endmodule

// File: rtl/cfgwin_size_dec.sv
module cfgwin_size_dec
  import cfgwin_pkg::*;
#(
  parameter int unsigned PA_W = 40
) (
  input  logic [PA_W-1:0]  reg_i,
  output logic             en_o,
  output logic [PA_W-1:0]  base_o,
  output logic [LEN_W-1:0] len_o,
  output logic             err_o
);
  localparam logic [PA_W-1:0] MASK_COARSE = {PA_W{1'b1}} << COARSE_LSB;
  localparam logic [PA_W-1:0] BIT26       = PA_W'(1) << 26;
  localparam logic [PA_W-1:0] BIT27       = PA_W'(1) << 27;

  win_size_e        sz;
  logic [PA_W-1:0]  mask;

  assign sz = win_size_e'(reg_i[SZ_LSB +: 2]);

  always_comb begin
    mask  = MASK_COARSE;
    len_o = '0;
    err_o = 1'b0;
    unique case (sz)
      SZ_256M: len_o = LEN_W'(1) << 28;
      SZ_128M: begin
        len_o = LEN_W'(1) << 27;
        mask  = MASK_COARSE | BIT27 | BIT26;
      end
      SZ_64M: begin
        len_o = LEN_W'(1) << 26;
        mask  = MASK_COARSE | BIT26;
      end
      SZ_RSVD: err_o = 1'b1;
      default: err_o = 1'b1;
    endcase
  end

  assign base_o = reg_i & mask;
  assign en_o   = reg_i[EN_BIT] && !err_o;
endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match
  import cfgwin_pkg::*;
#(
  parameter int unsigned PA_W      = 40,
  parameter logic [63:0] DEF_BASE  = 64'h4000_0000,
  parameter logic [31:0] APIC_BASE = 32'hFEC0_0000
) (
  input  logic             en_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PA_W-1:0]  addr_i,
  output logic             hit_o,
  output logic [31:0]      hole_start_o,
  output logic [31:0]      hole_end_o
);
  // one guard bit so a window at the top of the space does not wrap
  logic [PA_W:0] limit;
  logic          above_lo;
  logic          below_hi;

  assign limit    = {1'b0, base_i} + (PA_W+1)'(len_i);
  assign above_lo = addr_i >= base_i;
  assign below_hi = {1'b0, addr_i} < limit;
  assign hit_o    = en_i && above_lo && below_hi;

  assign hole_start_o = en_i ? limit[31:0] : DEF_BASE[31:0];
  assign hole_end_o   = APIC_BASE - 32'd1;
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int unsigned PA_W      = 40,
  parameter logic [63:0] DEF_BASE  = 64'h4000_0000,
  parameter logic [31:0] APIC_BASE = 32'hFEC0_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_be_i,
  input  logic [63:0]      wr_data_i,
  output logic [63:0]      rd_data_o,
  input  logic [PA_W-1:0]  addr_i,
  output logic             win_en_o,
  output logic [PA_W-1:0]  win_base_o,
  output logic [LEN_W-1:0] win_len_o,
  output logic             hit_o,
  output logic             len_err_o,
  output logic [31:0]      hole_start_o,
  output logic [31:0]      hole_end_o
);
  localparam int unsigned REG_W = 64;
  localparam logic [REG_W-1:0] BASE_BITS =
    ({REG_W{1'b1}} >> (REG_W - PA_W)) & ({REG_W{1'b1}} << BASE_LSB);
  localparam logic [REG_W-1:0] WMASK = BASE_BITS | REG_W'(7);

  logic [REG_W-1:0] reg_q;

  cfgwin_reg #(
    .REG_W   (REG_W),
    .RST_VAL (DEF_BASE),
    .WMASK   (WMASK)
  ) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .be_i    (wr_be_i),
    .d_i     (wr_data_i),
    .q_o     (reg_q)
  );

  cfgwin_size_dec #(.PA_W(PA_W)) u_dec (
    .reg_i  (reg_q[PA_W-1:0]),
    .en_o   (win_en_o),
    .base_o (win_base_o),
    .len_o  (win_len_o),
    .err_o  (len_err_o)
  );

  cfgwin_match #(
    .PA_W      (PA_W),
    .DEF_BASE  (DEF_BASE),
    .APIC_BASE (APIC_BASE)
  ) u_match (
    .en_i         (win_en_o),
    .base_i       (win_base_o),
    .len_i        (win_len_o),
    .addr_i       (addr_i),
    .hit_o        (hit_o),
    .hole_start_o (hole_start_o),
    .hole_end_o   (hole_end_o)
  );

  assign rd_data_o = reg_q;
endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk
  import cfgwin_pkg::*;
#(
  parameter int unsigned PA_W     = 40,
  parameter logic [63:0] DEF_BASE = 64'h4000_0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [63:0]      rd_data_o,
  input logic [PA_W-1:0]  addr_i,
  input logic             win_en_o,
  input logic [PA_W-1:0]  win_base_o,
  input logic [LEN_W-1:0] win_len_o,
  input logic             hit_o,
  input logic             len_err_o,
  input logic [31:0]      hole_start_o
);
  // R8
  rsvd_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> (!hit_o && !win_en_o));

  // R7
  hit_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (win_en_o && addr_i >= win_base_o));

  // R2
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

  // R4
  len_pow2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_len_o) && ((win_len_o == '0) == len_err_o));

  // R9
  hole_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_o |-> (hole_start_o == DEF_BASE[31:0]));

  // R6
  en_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[EN_BIT] |-> !win_en_o);

  // R3
  rsvd_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[25:3] == '0);
endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(
  .PA_W     (PA_W),
  .DEF_BASE (DEF_BASE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_data_o    (rd_data_o),
  .addr_i       (addr_i),
  .win_en_o     (win_en_o),
  .win_base_o   (win_base_o),
  .win_len_o    (win_len_o),
  .hit_o        (hit_o),
  .len_err_o    (len_err_o),
  .hole_start_o (hole_start_o)
);

// File: tb/sim_cfgwin_decoder.sv
module sim_cfgwin_decoder;
  localparam int unsigned PA_W = 40;
  localparam logic [63:0] WMASK_M = 64'h0000_00FF_FC00_0007;

  typedef struct packed {
    logic [7:0]      be;
    logic [63:0]     data;
    logic [PA_W-1:0] addr;
    logic            hit;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 64'h0000_0000_E000_0001, 40'h00_E000_0000, 1'b1},
    '{8'hFF, 64'h0000_0000_E000_0001, 40'h00_EFFF_FFFF, 1'b1},
    '{8'hFF, 64'h0000_0000_E000_0001, 40'h00_F000_0000, 1'b0},
    '{8'hFF, 64'h0000_0000_E000_0001, 40'h00_DFFF_FFFF, 1'b0},
    '{8'hFF, 64'h0000_0000_E400_0003, 40'h00_EBFF_FFFF, 1'b1},
    '{8'hFF, 64'h0000_0000_EC00_0005, 40'h00_E400_0010, 1'b1},
    '{8'hFF, 64'h0000_0000_EC00_0005, 40'h00_EC00_0000, 1'b0},
    '{8'hFF, 64'h0000_0000_EC00_0007, 40'h00_E000_0000, 1'b0},
    '{8'hFF, 64'h0000_0000_E000_0000, 40'h00_E000_0000, 1'b0},
    '{8'hFF, 64'h0000_0001_2000_0001, 40'h01_2000_0100, 1'b1},
    '{8'hFF, 64'h0000_0001_2000_0001, 40'h00_2000_0100, 1'b0},
    '{8'hFF, 64'hFFFF_FFFF_FFFF_FFF9, 40'hFF_FFFF_FFFF, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_be = '0;
  logic [63:0]     wr_data = '0;
  logic [63:0]     rd_data;
  logic [PA_W-1:0] addr = '0;
  logic            win_en;
  logic [PA_W-1:0] win_base;
  logic [28:0]     win_len;
  logic            hit;
  logic            len_err;
  logic [31:0]     hole_start;
  logic [31:0]     hole_end;

  int nchk = 0;
  int nfail = 0;
  logic [63:0] m_reg;

  always #4 clk = ~clk;

  cfgwin_decoder #(.PA_W(PA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_be_i(wr_be),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .addr_i(addr),
    .win_en_o(win_en), .win_base_o(win_base), .win_len_o(win_len),
    .hit_o(hit), .len_err_o(len_err), .hole_start_o(hole_start),
    .hole_end_o(hole_end)
  );

  // reference model derived from the requirements
  function automatic logic [28:0] m_len(input logic [63:0] r);
    case (r[2:1])
      2'b00:   return 29'h1000_0000;
      2'b01:   return 29'h0800_0000;
      2'b10:   return 29'h0400_0000;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] m_base(input logic [63:0] r);
    logic [PA_W-1:0] mk;
    case (r[2:1])
      2'b01:   mk = 40'hFF_FC00_0000;
      2'b10:   mk = 40'hFF_F400_0000;
      default: mk = 40'hFF_F000_0000;
    endcase
    return r[PA_W-1:0] & mk;
  endfunction

  function automatic logic m_en(input logic [63:0] r);
    return r[0] && (r[2:1] != 2'b11);
  endfunction

  function automatic logic [31:0] m_hole(input logic [63:0] r);
    logic [PA_W:0] s;
    s = {1'b0, m_base(r)} + (PA_W+1)'(m_len(r));
    return m_en(r) ? s[31:0] : 32'h4000_0000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_model(input string tag);
    chk({tag, " R3 rd_data"}, rd_data, m_reg);
    chk({tag, " R4 len"}, 64'(win_len), 64'(m_len(m_reg)));
    chk({tag, " R4 err"}, 64'(len_err), 64'(m_reg[2:1] == 2'b11));
    chk({tag, " R5 base"}, 64'(win_base), 64'(m_base(m_reg)));
    chk({tag, " R6 en"}, 64'(win_en), 64'(m_en(m_reg)));
    chk({tag, " R9 hole_start"}, 64'(hole_start), 64'(m_hole(m_reg)));
    chk({tag, " R10 hole_end"}, 64'(hole_end), 64'hFEBF_FFFF);
  endtask

  task automatic do_write(input logic en, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    wr_en = en; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
    if (en) begin
      for (int b = 0; b < 8; b++)
        if (be[b]) m_reg[b*8 +: 8] = d[b*8 +: 8] & WMASK_M[b*8 +: 8];
    end
  endtask

  task automatic probe(input logic [PA_W-1:0] a, input logic exp_hit, input string req);
    addr = a;
    #1;
    chk(req, 64'(hit), 64'(exp_hit));
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    m_reg = 64'h4000_0000;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 64'h4000_0000);
    chk("R1 win_en", 64'(win_en), 64'd0);
    chk("R1 hole_start", 64'(hole_start), 64'h4000_0000);
    chk("R1 len_err", 64'(len_err), 64'd0);
    probe(40'h00_4000_0000, 1'b0, "R1 hit");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_write(1'b1, VECS[i].be, VECS[i].data);
      check_model($sformatf("vec%0d", i));
      probe(VECS[i].addr, VECS[i].hit, $sformatf("vec%0d R7 R8 hit", i));
    end

    // R2 partial byte writes
    do_write(1'b1, 8'hFF, 64'h4000_0000);
    do_write(1'b1, 8'h01, 64'hFFFF_FFFF_FFFF_FF01);
    chk("R2 byte0 only", rd_data, 64'h4000_0001);
    probe(40'h00_4FFF_FFFF, 1'b1, "R2 R7 top byte hit");
    probe(40'h00_5000_0000, 1'b0, "R7 end byte miss");
    do_write(1'b1, 8'h08, 64'h0000_0000_8000_0000);
    chk("R2 byte3 only", rd_data, 64'h8000_0001);
    check_model("R2 partial");
    do_write(1'b0, 8'hFF, 64'h0000_0000_E000_0001);
    chk("R2 strobe low ignored", rd_data, 64'h8000_0001);
    probe(40'h00_8000_0000, 1'b1, "R2 window unchanged after ignored write");

    // R8 reserved code with enable set, sweep addresses
    do_write(1'b1, 8'h01, 64'h07);
    for (int k = 0; k < 4; k++)
      probe(40'h00_8000_0000 + 40'(k) * 40'h0400_0000, 1'b0, "R8 reserved no hit");
    check_model("R8 reserved");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    m_reg = 64'h4000_0000;
    #1;
    check_model("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule